// File: doc/BRIEF.md
# Offset Modulo-Five Up Counter

This block is a synchronous three-bit up counter whose range is shifted away from zero. It steps through the five codes 2, 3, 4, 5 and 6 and then returns to 2, so the codes 0, 1 and 7 are never part of its sequence. It moves one step on each rising clock edge at which the enable input is high, and it holds its value while the enable is low. A one-cycle wrap output marks the enabled cycle in which the count sits at 6, which is the cycle whose closing edge brings the count back to 2.

The next-state logic exists in two forms. One is written as behaviour: compare against the top of the range and either add one or reload the start code. The other is written as per-bit Boolean equations derived from the state table. A parameter picks which form drives the register; both are always built, and the two must produce the same next state for every register code. If an upset ever leaves the register at an unused code, the next enabled edge loads 2, so the counter rejoins its sequence in one step.

Top module: `offset_mod5_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge the count is loaded with 2 (binary 010), whatever `en` is, and `wrap` stays low during any cycle with `rst_n` low.
- R2: With `rst_n` and `en` high and the count at 2, 3, 4 or 5, the next rising edge loads the count plus one.
- R3: With `rst_n` and `en` high and the count at 6 (binary 110), the next rising edge loads 2.
- R4: While `en` is low (and `rst_n` high) the count keeps its value across clock edges and `wrap` is low.
- R5: `wrap` is high in exactly the cycles in which `rst_n` is high, `en` is high and the count is 6; it is a combinational output of the current cycle.
- R6: For the unused codes 0 (000), 1 (001) and 7 (111), the next-state value offered to the register is 2, so the next enabled edge leaves the unused code.
- R7: The behavioural and the Boolean-equation next-state forms give the same next state for all eight register codes, and a counter built with either form produces the same `count` and `wrap` on every cycle.
- R8: After reset, with any enable pattern, the count only ever takes the five values 2 to 6 and returns to its start after five enabled edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; loads the start code 2 |
| en | input | 1 | Count enable; high advances one step per edge, low holds |
| count | output | 3 | Current counter value, 2 to 6 in normal operation |
| wrap | output | 1 | High in the enabled cycle in which the count is 6 |

## Verification
The counter is run with enable held high long enough to wrap several times, which separates an off-by-one range or a wrong reload code from a correct one, and with enable toggling every cycle and held low across a count of 6, which shows whether holding is honoured and whether `wrap` leaks out while disabled. A reset applied while the count is 6 with enable high tells apart a design that lets `wrap` or the increment win over reset. Both next-state forms are also driven directly with all eight register codes, which is the only way to reach the unused codes 0, 1 and 7 and to confirm that the two forms match code for code; two counters, one per form, run side by side on the same stimulus.

// File: rtl/mod5_pkg.sv
// Package: mod5_pkg
// Shared width, range limits and the count type for the offset
// modulo-five counter. The range limits are the single source of the
// start and top codes used by every module of the block.
package mod5_pkg;

    localparam int CNT_W     = 3;
    localparam int CNT_SPAN  = 5;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_START = cnt_t'(2);
    localparam cnt_t CNT_LAST  = cnt_t'(CNT_START + CNT_SPAN - 1);

endpackage

// File: rtl/mod5_next_behav.sv
// Module: mod5_next_behav
// Behavioural next-state logic. Given the present code it returns the
// code the register should take on an enabled edge: one more for codes
// inside the range below the top, the start code for the top code and
// for any code outside the range. Also flags the top code.
// Assumes: CNT_START < CNT_LAST and both fit in CNT_W bits.
module mod5_next_behav
    import mod5_pkg::*;
(
    input  cnt_t cur,
    output cnt_t nxt,
    output logic at_last
);

    // Pick increment or reload from a range comparison.
    always_comb begin
        if ((cur >= CNT_START) && (cur < CNT_LAST)) begin
            nxt = cur + cnt_t'(1);
        end else begin
            nxt = CNT_START;
        end
    end

    // Top-of-range detect used for the wrap output.
    assign at_last = (cur == CNT_LAST);

endmodule

// File: rtl/mod5_next_eqn.sv
// Module: mod5_next_eqn
// Gate-level next-state logic written from the state table of the
// 2..6 counter, one equation per register bit. Unused codes 0, 1 and
// 7 map to 2 (binary 010), the same as the top code 6.
// Assumes: the package defaults (3 bits, start 2, top 6); the
// equations are not regenerated for other ranges.
module mod5_next_eqn
    import mod5_pkg::*;
(
    input  cnt_t cur,
    output cnt_t nxt,
    output logic at_last
);

    logic b2;
    logic b1;
    logic b0;
    logic hi_diff;
    logic lo_same;

    // Split the code into named bits for the equations.
    assign b2 = cur[2];
    assign b1 = cur[1];
    assign b0 = cur[0];

    // Shared product terms.
    assign hi_diff = b2 ^ b1;
    assign lo_same = ~(b1 ^ b0);

    // Bit 2 is set only when going 3->4, 4->5 or 5->6.
    assign nxt[2] = (~b2 & b1 & b0) | (b2 & ~b1);
    // Bit 1 is clear only when going 3->4 or 4->5.
    assign nxt[1] = ~(hi_diff & lo_same);
    // Bit 0 is set only when going 2->3 or 4->5.
    assign nxt[0] = ~b0 & hi_diff;

    // Top code 110.
    assign at_last = b2 & b1 & ~b0;

endmodule

// File: rtl/mod5_state_reg.sv
// Module: mod5_state_reg
// The counter register with synchronous active-low reset to the start
// code and a load enable. Holds its value while the enable is low.
// Assumes: reset has priority over the enable.
module mod5_state_reg
    import mod5_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  cnt_t d,
    output cnt_t q
);

    // Register update: reset, then load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= CNT_START;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/offset_mod5_counter.sv
// Module: offset_mod5_counter
// Top of the offset modulo-five counter. Builds both next-state forms,
// selects one through USE_EQN to drive the register, and produces the
// wrap output for the enabled cycle at the top code.
// Assumes: USE_EQN = 1 only with the package default range.
module offset_mod5_counter
    import mod5_pkg::*;
#(
    parameter bit USE_EQN = 1'b0
)
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    cnt_t cnt_q;
    cnt_t nxt_behav;
    cnt_t nxt_eqn;
    cnt_t nxt_sel;
    logic last_behav;
    logic last_eqn;
    logic last_sel;

    mod5_next_behav u_next_behav (
        .cur     (cnt_q),
        .nxt     (nxt_behav),
        .at_last (last_behav)
    );

    mod5_next_eqn u_next_eqn (
        .cur     (cnt_q),
        .nxt     (nxt_eqn),
        .at_last (last_eqn)
    );

    // Choose which next-state form drives the register.
    generate
        if (USE_EQN) begin : g_eqn
            assign nxt_sel  = nxt_eqn;
            assign last_sel = last_eqn;
        end else begin : g_behav
            assign nxt_sel  = nxt_behav;
            assign last_sel = last_behav;
        end
    endgenerate

    mod5_state_reg u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (en),
        .d     (nxt_sel),
        .q     (cnt_q)
    );

    // Outputs: present count and the gated wrap marker.
    assign count = cnt_q;
    assign wrap  = rst_n & en & last_sel;

endmodule

// File: rtl/offset_mod5_counter_chk.sv
// Module: offset_mod5_counter_chk
// Property checker for offset_mod5_counter, attached by bind below.
// Assumes: reset is applied from time zero.
module offset_mod5_counter_chk
    import mod5_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic en,
    input cnt_t count,
    input logic wrap,
    input cnt_t nxt_behav,
    input cnt_t nxt_eqn
);

    // R1: reset loads the start code.
    assert_reset_start_R1: assert property (@(posedge clk)
        !rst_n |=> (count == CNT_START));

    // R1: no wrap while reset is asserted.
    assert_reset_nowrap_R1: assert property (@(posedge clk)
        !rst_n |-> !wrap);

    // R2: enabled step inside the range adds one.
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (count >= CNT_START) && (count < CNT_LAST))
        |=> (count == $past(count) + cnt_t'(1)));

    // R3: enabled step at the top reloads the start.
    assert_wrap_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (count == CNT_LAST)) |=> (count == CNT_START));

    // R4: disabled edges hold the count.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));

    // R5: wrap only with enable and followed by the start code.
    assert_wrap_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> en);
    assert_wrap_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == CNT_START));

    // R6: unused codes leave on the next enabled edge.
    assert_unused_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ((count < CNT_START) || (count > CNT_LAST)))
        |=> (count == CNT_START));

    // R7: both next-state forms agree.
    assert_forms_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_behav == nxt_eqn);

    // R8: count stays inside the range after reset.
    assert_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= CNT_START) && (count <= CNT_LAST));

endmodule

bind offset_mod5_counter offset_mod5_counter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .count     (count),
    .wrap      (wrap),
    .nxt_behav (nxt_behav),
    .nxt_eqn   (nxt_eqn)
);

// File: tb/offset_mod5_counter_tb.sv
// Scoreboard bench: the driver computes expected count and wrap from
// the requirements and queues them; the monitor pops and compares.
module offset_mod5_counter_tb;
    import mod5_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [2:0] count_b;
    logic [2:0] count_e;
    logic wrap_b;
    logic wrap_e;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [2:0] exp_cnt_q[$];
    logic       exp_wrp_q[$];
    string      exp_req_q[$];

    logic [2:0] mcount = 3'd2;

    cnt_t probe = '0;
    cnt_t pn_b;
    cnt_t pn_e;
    logic pl_b;
    logic pl_e;

    always #(CLK_PERIOD/2) clk = ~clk;

    offset_mod5_counter #(.USE_EQN(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .count(count_b), .wrap(wrap_b)
    );

    offset_mod5_counter #(.USE_EQN(1'b1)) u_dut_eqn (
        .clk(clk), .rst_n(rst_n), .en(en), .count(count_e), .wrap(wrap_e)
    );

    mod5_next_behav u_probe_b (.cur(probe), .nxt(pn_b), .at_last(pl_b));
    mod5_next_eqn   u_probe_e (.cur(probe), .nxt(pn_e), .at_last(pl_e));

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue its expectation.
    task automatic drive(input logic r, input logic e, input string req);
        @(negedge clk);
        rst_n = r;
        en = e;
        #1;
        exp_cnt_q.push_back(mcount);
        exp_wrp_q.push_back(r && e && (mcount == 3'd6));
        exp_req_q.push_back(req);
        if (!r) mcount = 3'd2;
        else if (e) mcount = (mcount >= 3'd2 && mcount < 3'd6) ? mcount + 3'd1 : 3'd2;
    endtask

    // Monitor: compare both counters against the queued expectation.
    always @(negedge clk) begin
        #2;
        if (exp_cnt_q.size() != 0) begin
            automatic logic [2:0] ec = exp_cnt_q.pop_front();
            automatic logic ew = exp_wrp_q.pop_front();
            automatic string rq = exp_req_q.pop_front();
            check(rq, "count", int'(count_b), int'(ec));
            check(rq, "wrap", int'(wrap_b), int'(ew));
            check({rq, "/R7"}, "eqn count", int'(count_e), int'(ec));
            check({rq, "/R7"}, "eqn wrap", int'(wrap_e), int'(ew));
        end
    end

    initial begin
        // Reset cycles: first edge initialises the register (R1).
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b1;
        @(negedge clk);
        drive(1'b0, 1'b1, "R1");
        drive(1'b0, 1'b0, "R1");
        // Long enabled run: several wraps (R2, R3, R5, R8).
        for (int i = 0; i < 13; i++) drive(1'b1, 1'b1, "R2_R3_R8");
        // Alternating enable (R4).
        for (int i = 0; i < 10; i++) drive(1'b1, i[0], "R4");
        // Reach 6, then hold there with enable low (R4, R5).
        while (mcount != 3'd6) drive(1'b1, 1'b1, "R2");
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, "R4_R5");
        drive(1'b1, 1'b1, "R5");
        drive(1'b1, 1'b1, "R3");
        // Reset while at 6 with enable high (R1 wins over wrap).
        while (mcount != 3'd6) drive(1'b1, 1'b1, "R2");
        drive(1'b0, 1'b1, "R1");
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b1, "R8");
        @(negedge clk);
        @(negedge clk);

        // Direct next-state checks for every code (R2, R3, R6, R7).
        for (int c = 0; c < 8; c++) begin
            automatic int exp_n = (c >= 2 && c < 6) ? c + 1 : 2;
            automatic string rq = (c < 2 || c == 7) ? "R6" : (c == 6) ? "R3" : "R2";
            probe = cnt_t'(c);
            #1;
            check(rq, "behav next", int'(pn_b), exp_n);
            check({rq, "/R7"}, "eqn next", int'(pn_e), exp_n);
            check("R5", "behav top flag", int'(pl_b), int'(c == 6));
            check("R5", "eqn top flag", int'(pl_e), int'(c == 6));
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule